// File: doc/BRIEF.md
# Bit Field and Byte Reorder Unit

This block is a 32-bit data-manipulation stage for an integer pipeline. It handles two groups of operations. The first group works on a field described by a start position and a length: it can clear the field in a destination word, insert the low bits of a source word into that field, or pull the field out of a source word as an unsigned or a signed value. The second group works on the whole word: it counts leading zeros, reverses the bit order, swaps bytes across the word or within each halfword, byte-swaps the low halfword and sign-extends the result, and sign-extends a byte or a halfword.

A single shared mask generator turns the start position and the length into a field mask. All four field operations use that mask. A field that would run past bit 31 is cut off at bit 31. A length of zero describes an empty field.

The caller presents one operation per cycle with `in_valid`. The result is registered and comes out one cycle later with `out_valid`. Between operations the result register keeps its last value.

Top module: `bitfield_reorder_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` becomes 0 and `result` becomes 0.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. When `in_valid` is low, `result` keeps its previous value.
- R3: Opcode 0 (field clear) returns `dst` with the field bits forced to 0. All other bits of `dst` are unchanged.
- R4: Opcode 1 (field insert) returns `dst` with the field replaced by the low bits of `src`. All bits outside the field come from `dst`.
- R5: Opcode 2 (unsigned extract) returns the field of `src`, shifted down to bit 0, with zeros above it.
- R6: Opcode 3 (signed extract) behaves like opcode 2, except that the bits above the field copy the field's highest bit. An empty field returns 0.
- R7: The field covers the bits from `lsb` up to `lsb + len - 1`, where `len` is `width` limited to 32. Bits above bit 31 are dropped. A `width` of 0 gives an empty field.
- R8: Opcode 4 returns the number of zero bits above the highest set bit of `src`. If `src` is 0, it returns 32.
- R9: Opcode 5 returns `src` with bit i moved to bit 31 − i, for every i.
- R10: Opcode 6 reverses the four bytes of `src`. Opcode 7 swaps the two bytes inside each 16-bit half of `src`.
- R11: Opcode 8 returns `{src[7:0], src[15:8]}` sign-extended from bit 15 to 32 bits.
- R12: Opcode 9 copies `src[7]` into bits 31:8 above `src[7:0]`. Opcode 10 copies `src[15]` into bits 31:16 above `src[15:0]`.
- R13: Opcodes 11 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation select, encoded as in the requirements |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand for field clear and insert |
| lsb | input | 5 | Lowest bit position of the field |
| width | input | 6 | Field length; values above 32 count as 32 |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 32 | Registered result |

## Verification
The bench sweeps every `lsb` value against lengths from 0 to 33, plus 63, for all four field operations. It checks each result bit by bit against a model of the field range. This sweep exposes three kinds of fault:
- A mask that wraps around or is one bit short at the top.
- Signed extract taking its fill bit from the untruncated field top.
- A length of 32 or more producing an empty mask.

Leading-zero counting is tried on zero, every single-bit word and pseudo-random words. A count that saturates at 31, or that tracks the lowest set bit, shows up there. The reorder, sign-extension and unused opcodes run over pseudo-random words, so a byte placed in the wrong lane or a wrong sign source is caught. A separate idle-period check catches a result register that loads without `in_valid`.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        OP_FCLR  = 4'd0,
        OP_FINS  = 4'd1,
        OP_UEXT  = 4'd2,
        OP_SEXT  = 4'd3,
        OP_CLZ   = 4'd4,
        OP_BREV  = 4'd5,
        OP_REVW  = 4'd6,
        OP_REVH  = 4'd7,
        OP_REVSH = 4'd8,
        OP_SXB   = 4'd9,
        OP_SXH   = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        SRC_FIELD,
        SRC_COUNT,
        SRC_REORDER,
        SRC_NONE
    } res_sel_e;

    function automatic res_sel_e route(input op_e op);
        case (op)
            OP_FCLR, OP_FINS, OP_UEXT, OP_SEXT:                return SRC_FIELD;
            OP_CLZ:                                            return SRC_COUNT;
            OP_BREV, OP_REVW, OP_REVH, OP_REVSH, OP_SXB, OP_SXH: return SRC_REORDER;
            default:                                           return SRC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fbr_geom.sv
module fbr_geom #(
    parameter int DATA_W = fbr_pkg::WORD_W,
    localparam int POS_W = $clog2(DATA_W),
    localparam int LEN_W = POS_W + 1
) (
    input  logic [POS_W-1:0]  lsb,
    input  logic [LEN_W-1:0]  width,
    output logic [DATA_W-1:0] low_mask,
    output logic [DATA_W-1:0] field_mask,
    output logic [POS_W-1:0]  top_pos,
    output logic              empty
);
    logic [LEN_W-1:0] room;
    logic [LEN_W-1:0] len_req;
    logic [LEN_W-1:0] len;
    logic [LEN_W:0]   top_full;

    always_comb begin
        room     = LEN_W'(DATA_W) - LEN_W'(lsb);
        len_req  = (width > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : width;
        len      = (len_req > room) ? room : len_req;
        empty    = (len == '0);
        if (len == LEN_W'(DATA_W))
            low_mask = '1;
        else
            low_mask = (DATA_W'(1) << len) - DATA_W'(1);
        field_mask = low_mask << lsb;
        top_full   = {1'b0, LEN_W'(lsb)} + {1'b0, len} - (LEN_W+1)'(1);
        top_pos    = empty ? lsb : top_full[POS_W-1:0];
    end
endmodule

// File: rtl/fbr_field.sv
module fbr_field #(
    parameter int DATA_W = fbr_pkg::WORD_W,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  fbr_pkg::op_e      op,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  logic [POS_W-1:0]  lsb,
    input  logic [DATA_W-1:0] low_mask,
    input  logic [DATA_W-1:0] field_mask,
    input  logic [POS_W-1:0]  top_pos,
    input  logic              empty,
    output logic [DATA_W-1:0] res
);
    import fbr_pkg::*;

    logic [DATA_W-1:0] pulled;
    logic [DATA_W-1:0] placed;
    logic              sign_bit;

    always_comb begin
        pulled   = (src >> lsb) & low_mask;
        placed   = (src << lsb) & field_mask;
        sign_bit = src[top_pos] & ~empty;
        case (op)
            OP_FCLR: res = dst & ~field_mask;
            OP_FINS: res = (dst & ~field_mask) | placed;
            OP_UEXT: res = pulled;
            OP_SEXT: res = pulled | (sign_bit ? ~low_mask : '0);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/fbr_clz.sv
module fbr_clz #(
    parameter int DATA_W = fbr_pkg::WORD_W,
    localparam int LEN_W = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] src,
    output logic [LEN_W-1:0]  count
);
    always_comb begin
        count = LEN_W'(DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            if (src[i]) count = LEN_W'(DATA_W - 1 - i);
        end
    end
endmodule

// File: rtl/fbr_reorder.sv
module fbr_reorder #(
    parameter int DATA_W = fbr_pkg::WORD_W,
    localparam int NBYTE = DATA_W / 8,
    localparam int NHALF = DATA_W / 16
) (
    input  fbr_pkg::op_e      op,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] res
);
    import fbr_pkg::*;

    logic [DATA_W-1:0] bit_rev;
    logic [DATA_W-1:0] byte_rev;
    logic [DATA_W-1:0] half_swap;
    logic [DATA_W-1:0] low_swap_sx;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign bit_rev[i] = src[DATA_W-1-i];
    end

    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        assign byte_rev[8*b +: 8] = src[8*(NBYTE-1-b) +: 8];
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign half_swap[16*h +: 8]     = src[16*h + 8 +: 8];
        assign half_swap[16*h + 8 +: 8] = src[16*h +: 8];
    end

    assign low_swap_sx = {{(DATA_W-16){src[7]}}, src[7:0], src[15:8]};

    always_comb begin
        case (op)
            OP_BREV:  res = bit_rev;
            OP_REVW:  res = byte_rev;
            OP_REVH:  res = half_swap;
            OP_REVSH: res = low_swap_sx;
            OP_SXB:   res = {{(DATA_W-8){src[7]}}, src[7:0]};
            OP_SXH:   res = {{(DATA_W-16){src[15]}}, src[15:0]};
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/bitfield_reorder_unit.sv
module bitfield_reorder_unit #(
    parameter int DATA_W = fbr_pkg::WORD_W,
    localparam int POS_W = $clog2(DATA_W),
    localparam int LEN_W = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  logic [POS_W-1:0]  lsb,
    input  logic [LEN_W-1:0]  width,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    import fbr_pkg::*;

    op_e               op;
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] field_mask;
    logic [POS_W-1:0]  top_pos;
    logic              empty;
    logic [DATA_W-1:0] field_res;
    logic [LEN_W-1:0]  zero_cnt;
    logic [DATA_W-1:0] reorder_res;
    logic [DATA_W-1:0] next_res;

    assign op = op_e'(opcode);

    fbr_geom #(.DATA_W(DATA_W)) u_geom (
        .lsb        (lsb),
        .width      (width),
        .low_mask   (low_mask),
        .field_mask (field_mask),
        .top_pos    (top_pos),
        .empty      (empty)
    );

    fbr_field #(.DATA_W(DATA_W)) u_field (
        .op         (op),
        .src        (src),
        .dst        (dst),
        .lsb        (lsb),
        .low_mask   (low_mask),
        .field_mask (field_mask),
        .top_pos    (top_pos),
        .empty      (empty),
        .res        (field_res)
    );

    fbr_clz #(.DATA_W(DATA_W)) u_clz (
        .src   (src),
        .count (zero_cnt)
    );

    fbr_reorder #(.DATA_W(DATA_W)) u_reorder (
        .op  (op),
        .src (src),
        .res (reorder_res)
    );

    always_comb begin
        case (route(op))
            SRC_FIELD:   next_res = field_res;
            SRC_COUNT:   next_res = DATA_W'(zero_cnt);
            SRC_REORDER: next_res = reorder_res;
            default:     next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_res;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R3
    clear_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_FCLR) |=>
        ((result & ~$past(field_mask)) == ($past(dst) & ~$past(field_mask)))
        && ((result & $past(field_mask)) == '0));

    // R8
    clz_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_CLZ && src == '0) |=> (result == DATA_W'(DATA_W)));

    // R12
    sext_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_SXB) |=> (result[DATA_W-1:8] == {(DATA_W-8){$past(src[7])}}));
endmodule

// File: tb/bitfield_reorder_unit_tb.sv
module bitfield_reorder_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  opcode;
    logic [31:0] src;
    logic [31:0] dst;
    logic [4:0]  lsb;
    logic [5:0]  width;
    logic        out_valid;
    logic [31:0] result;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bitfield_reorder_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .src       (src),
        .dst       (dst),
        .lsb       (lsb),
        .width     (width),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [31:0] model_field(input logic [3:0] op, input logic [31:0] s,
                                                input logic [31:0] d, input int l, input int w);
        int wc, hi, n;
        logic [31:0] r;
        wc = (w > 32) ? 32 : w;
        hi = (l + wc > 32) ? 32 : l + wc;
        n  = hi - l;
        r  = '0;
        for (int i = 0; i < 32; i++) begin
            case (op)
                4'd0: r[i] = (i >= l && i < hi) ? 1'b0 : d[i];
                4'd1: r[i] = (i >= l && i < hi) ? s[i-l] : d[i];
                default: begin
                    if (i < n) r[i] = s[i+l];
                    else if (op == 4'd3 && n > 0) r[i] = s[hi-1];
                    else r[i] = 1'b0;
                end
            endcase
        end
        return r;
    endfunction

    function automatic logic [31:0] model_word(input logic [3:0] op, input logic [31:0] s);
        logic [31:0] r;
        int z;
        case (op)
            4'd4: begin
                z = 0;
                for (int i = 31; i >= 0; i--) begin
                    if (s[i]) break;
                    z++;
                end
                r = 32'(z);
            end
            4'd5: for (int i = 0; i < 32; i++) r[i] = s[31-i];
            4'd6: r = {s[7:0], s[15:8], s[23:16], s[31:24]};
            4'd7: r = {s[23:16], s[31:24], s[7:0], s[15:8]};
            4'd8: r = {{16{s[7]}}, s[7:0], s[15:8]};
            4'd9: r = {{24{s[7]}}, s[7:0]};
            4'd10: r = {{16{s[15]}}, s[15:0]};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [31:0] s, input logic [31:0] d,
                       input int l, input int w, input logic [31:0] exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        opcode   = op;
        src      = s;
        dst      = d;
        lsb      = 5'(l);
        width    = 6'(w);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        check(tag, result, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [31:0] held;
        logic [31:0] spats [2];
        logic [31:0] dpats [2];
        string       tag;

        spats[0] = 32'hA5C3_96F0;
        spats[1] = 32'h8001_7FFE;
        dpats[0] = 32'h1234_5678;
        dpats[1] = 32'hFFFF_0000;

        rst = 1'b1; in_valid = 1'b0; opcode = '0; src = '0; dst = '0; lsb = '0; width = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        rst = 1'b0;

        // R3 R4 R5 R6 R7 field sweep
        for (int p = 0; p < 2; p++) begin
            for (int op = 0; op < 4; op++) begin
                for (int l = 0; l < 32; l++) begin
                    for (int w = 0; w < 35; w++) begin
                        int wv;
                        wv = (w == 34) ? 63 : w;
                        if (wv == 0 || wv > 32 || l + wv > 32) tag = "R7";
                        else if (op == 0) tag = "R3";
                        else if (op == 1) tag = "R4";
                        else if (op == 2) tag = "R5";
                        else tag = "R6";
                        run(4'(op), spats[p], dpats[p], l, wv,
                            model_field(4'(op), spats[p], dpats[p], l, wv), tag);
                    end
                end
            end
        end

        // R8 zero and single-bit inputs
        run(4'd4, 32'd0, 32'd0, 0, 0, 32'd32, "R8");
        for (int i = 0; i < 32; i++)
            run(4'd4, 32'd1 << i, 32'd0, 0, 0, 32'(31 - i), "R8");

        // R8 R9 R10 R11 R12 R13 random words
        seed = 32'h1BAD_F00D;
        for (int k = 0; k < 200; k++) begin
            for (int op = 4; op < 16; op++) begin
                seed = next_rand(seed);
                if (op == 4) tag = "R8";
                else if (op == 5) tag = "R9";
                else if (op <= 7) tag = "R10";
                else if (op == 8) tag = "R11";
                else if (op <= 10) tag = "R12";
                else tag = "R13";
                run(4'(op), (op == 4) ? (seed >> (k % 32)) : seed, ~seed, k % 32, k % 40,
                    model_word(4'(op), (op == 4) ? (seed >> (k % 32)) : seed), tag);
            end
        end

        // R2 result holds while idle, inputs changing
        run(4'd6, 32'hDEAD_BEEF, 32'd0, 0, 0, 32'hEFBE_ADDE, "R2");
        held = result;
        for (int k = 0; k < 4; k++) begin
            seed = next_rand(seed);
            opcode = 4'(k + 5);
            src    = seed;
            dst    = ~seed;
            @(negedge clk);
            check("R2 idle valid", {31'd0, out_valid}, 32'd0);
            check("R2 hold", result, held);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule